// File: doc/BRIEF.md
# Fetch Group Extractor

This block sits between an instruction cache and the decode queue of one fetch thread. Each cycle in which a fetched 64-byte line is presented for the thread's current PC, it cuts a group of up to `SLOTS` 4-byte instructions out of that line. Each group starts at the word the PC points into. Every slot in the group carries the instruction word, its PC, a sequence number and a predicted next PC. It also forms the line-aligned request address that the cache needs for the next access.

A group stops at the first of four events: the last word of the line, the slot limit, a control instruction that the per-slot predictor inputs mark taken, or a quiesce instruction. After each group the thread PC moves to the predicted next PC of its last slot. A translation fault reported with the line turns the group into a single nop slot that carries the fault code, and the thread then waits for a redirect. A quiesce instruction does the same after it has been emitted. A redirect loads a new PC and clears both waiting conditions.

Top module: `fx_group_extract`

## Requirements
- R1: While reset is held and after it is released, no slot is valid, the fault flag and both pending flags are low, the thread PC is `RESET_PC`, the next-PC register is `RESET_PC`+4 and the first sequence number handed out is 0.
- R2: `req_addr` is always the thread PC with its 6 low bits cleared. A group starts at byte offset (PC mod 64) with bits 1:0 forced to zero, and slot i carries PC `req_addr` + offset + 4·i.
- R3: Without a taken branch or quiesce, a group holds min(SLOTS, (64 − offset)/4) slots. The valid mask is filled from slot 0 upward without gaps. `slot_count` equals the number of valid slots, and `wr_active` is high exactly when at least one slot is valid.
- R4: A non-control instruction gets the predicted next PC of its own PC plus 4. An instruction is a control instruction when bits 31:30 are 2'b10.
- R5: Sequence numbers rise by one per emitted slot, both within a group and from one group to the next, and the fault nop also takes one.
- R6: A control instruction whose slot has `pred_taken` set gets the slot's `pred_target` as its next PC and is the last slot of the group. A control instruction whose slot is not marked taken gets PC+4, and the group continues.
- R7: A quiesce instruction (bits 31:24 equal 8'h7F) is emitted and counted. It gets PC+4, ends the group and sets `quiesce_pending`.
- R8: A presented line with `fetch_fault` set yields exactly one valid slot. That slot holds the nop word 32'h0000_0013, the PC of the starting word, that PC+4 as next PC, `slot_fault` high and `slot_fault_code` equal to `fault_code`. It sets `trap_pending` and leaves the thread PC unchanged.
- R9: After a normal group, the thread PC equals the next PC of the group's last slot, and the next-PC register holds that value plus 4.
- R10: While `quiesce_pending` or `trap_pending` is set, a presented line produces no slot and changes neither the PCs nor the sequence number.
- R11: A redirect sets the thread PC to `redirect_pc` and the next-PC register to `redirect_pc`+4, and clears both pending flags. A line presented in the same cycle is discarded.
- R12: Slot outputs, the thread PC and `req_addr` all change at the clock edge that accepts the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| redirect_valid | input | 1 | Load a new thread PC this cycle |
| redirect_pc | input | ADDR_W | PC to load on redirect |
| fetch_valid | input | 1 | A line for the current PC is presented |
| fetch_fault | input | 1 | Translation of the presented access faulted |
| fault_code | input | FAULT_W | Fault cause carried by the nop slot |
| line_data | input | 512 | Line bytes; byte b sits at bits 8b+7:8b |
| pred_taken | input | SLOTS | Predictor taken flag per slot |
| pred_target | input | SLOTS·ADDR_W | Predictor target per slot |
| req_addr | output | ADDR_W | Line-aligned request address |
| thread_pc | output | ADDR_W | Current thread PC |
| thread_npc | output | ADDR_W | Next-PC register |
| slot_valid | output | SLOTS | Valid mask of the last group |
| slot_count | output | clog2(SLOTS+1) | Number of valid slots |
| wr_active | output | 1 | At least one slot is valid |
| slot_inst | output | SLOTS·32 | Instruction words |
| slot_pc | output | SLOTS·ADDR_W | PC of each slot |
| slot_seq | output | SLOTS·SEQ_W | Sequence number of each slot |
| slot_npc | output | SLOTS·ADDR_W | Predicted next PC of each slot |
| slot_fault | output | 1 | The group is a fault nop |
| slot_fault_code | output | FAULT_W | Fault cause of the nop |
| quiesce_pending | output | 1 | A quiesce was emitted; waiting for redirect |
| trap_pending | output | 1 | A fault nop was emitted; waiting for redirect |

## Verification
Two events can land in the same cycle, and each case is provoked on purpose. In the first, a redirect arrives together with a presented line. The bench expects no slot and a thread PC equal to the redirect target. A design that lets the fetch win shows slots or a PC past the target. In the second, a taken branch sits in the last word of the line, so the line-end stop and the branch stop fall on the same slot. The bench expects exactly one slot, and the next thread PC must be the branch target, not the start of the following line.

// File: rtl/fx_pkg.sv
package fx_pkg;
  localparam int LINE_BYTES = 64;
  localparam int LINE_BITS  = LINE_BYTES * 8;
  localparam int OFF_W      = $clog2(LINE_BYTES);
  localparam int INST_W     = 32;
  localparam int INST_BYTES = INST_W / 8;
  localparam logic [INST_W-1:0] NOP_WORD = 32'h0000_0013;

  // control transfer: top two bits 2'b10
  function automatic logic is_ctrl(input logic [INST_W-1:0] w);
    return w[31:30] == 2'b10;
  endfunction

  // quiesce: top byte 8'h7F
  function automatic logic is_quiesce(input logic [INST_W-1:0] w);
    return w[31:24] == 8'h7F;
  endfunction

  // starting byte offset inside the line, word aligned
  function automatic logic [OFF_W-1:0] word_off(input logic [OFF_W-1:0] low);
    return low & ~OFF_W'(INST_BYTES - 1);
  endfunction
endpackage

// File: rtl/fx_slot_chain.sv
module fx_slot_chain
  import fx_pkg::*;
#(
  parameter int SLOTS  = 4,
  parameter int ADDR_W = 32,
  parameter int CNT_W  = $clog2(SLOTS + 1)
) (
  input  logic [ADDR_W-1:0]        pc,
  input  logic [LINE_BITS-1:0]     line,
  input  logic [SLOTS-1:0]         taken,
  input  logic [SLOTS*ADDR_W-1:0]  target,
  output logic [SLOTS-1:0]         valid,
  output logic [SLOTS*INST_W-1:0]  insts,
  output logic [SLOTS*ADDR_W-1:0]  spcs,
  output logic [SLOTS*ADDR_W-1:0]  npcs,
  output logic [CNT_W-1:0]         count,
  output logic [ADDR_W-1:0]        last_npc,
  output logic                     quiesce_hit
);
  localparam int OW = OFF_W + $clog2(SLOTS) + 3;

  logic [ADDR_W-1:0] base;
  logic [OFF_W-1:0]  off0;
  logic [SLOTS-1:0]  run;
  logic [SLOTS-1:0]  qhit;

  assign base   = {pc[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign off0   = word_off(pc[OFF_W-1:0]);
  assign run[0] = 1'b1;

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    logic [OW-1:0]     off_i;
    logic              in_line;
    logic [INST_W-1:0] w;
    logic              br_taken;
    logic              ends;
    logic [ADDR_W-1:0] spc;

    assign off_i    = OW'(off0) + OW'(INST_BYTES * i);
    assign in_line  = off_i < OW'(LINE_BYTES);
    assign w        = line[{off_i[OFF_W-1:0], 3'b000} +: INST_W];
    assign br_taken = is_ctrl(w) && taken[i];
    assign valid[i] = run[i] && in_line;
    assign ends     = br_taken || is_quiesce(w);
    assign qhit[i]  = valid[i] && is_quiesce(w);
    assign spc      = base + ADDR_W'(off_i);

    assign insts[i*INST_W +: INST_W] = w;
    assign spcs[i*ADDR_W +: ADDR_W]  = spc;
    assign npcs[i*ADDR_W +: ADDR_W]  = br_taken ? target[i*ADDR_W +: ADDR_W]
                                                : spc + ADDR_W'(INST_BYTES);
    if (i < SLOTS - 1) begin : g_next
      assign run[i+1] = valid[i] && !ends;
    end
  end

  always_comb begin
    count    = '0;
    last_npc = npcs[ADDR_W-1:0];
    for (int i = 0; i < SLOTS; i++) begin
      if (valid[i]) begin
        count    = count + CNT_W'(1);
        last_npc = npcs[i*ADDR_W +: ADDR_W];
      end
    end
  end

  assign quiesce_hit = |qhit;
endmodule

// File: rtl/fx_thread_state.sv
module fx_thread_state #(
  parameter int              ADDR_W   = 32,
  parameter int              SEQ_W    = 16,
  parameter int              CNT_W    = 3,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              redirect_valid,
  input  logic [ADDR_W-1:0] redirect_pc,
  input  logic              fetch_valid,
  input  logic              fetch_fault,
  input  logic [CNT_W-1:0]  count,
  input  logic [ADDR_W-1:0] last_npc,
  input  logic              quiesce_hit,
  output logic [ADDR_W-1:0] pc_q,
  output logic [ADDR_W-1:0] npc_q,
  output logic [SEQ_W-1:0]  seq_q,
  output logic              qp_q,
  output logic              tp_q,
  output logic              accept
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);

  assign accept = fetch_valid && !redirect_valid && !qp_q && !tp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q  <= RESET_PC;
      npc_q <= RESET_PC + STEP;
      seq_q <= '0;
      qp_q  <= 1'b0;
      tp_q  <= 1'b0;
    end else if (redirect_valid) begin
      pc_q  <= redirect_pc;
      npc_q <= redirect_pc + STEP;
      qp_q  <= 1'b0;
      tp_q  <= 1'b0;
    end else if (accept) begin
      if (fetch_fault) begin
        tp_q  <= 1'b1;
        seq_q <= seq_q + SEQ_W'(1);
      end else begin
        pc_q  <= last_npc;
        npc_q <= last_npc + STEP;
        seq_q <= seq_q + SEQ_W'(count);
        if (quiesce_hit) qp_q <= 1'b1;
      end
    end
  end

  // a waiting thread holds its PC and sequence number
  a_r10_hold_state: assert property (@(posedge clk) disable iff (!rst_n)
    (qp_q || tp_q) && !redirect_valid |=> pc_q == $past(pc_q) && seq_q == $past(seq_q));
endmodule

// File: rtl/fx_group_extract.sv
module fx_group_extract
  import fx_pkg::*;
#(
  parameter int                SLOTS    = 4,
  parameter int                ADDR_W   = 32,
  parameter int                SEQ_W    = 16,
  parameter int                FAULT_W  = 4,
  parameter logic [ADDR_W-1:0] RESET_PC = 32'h0000_1000,
  localparam int               CNT_W    = $clog2(SLOTS + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     redirect_valid,
  input  logic [ADDR_W-1:0]        redirect_pc,
  input  logic                     fetch_valid,
  input  logic                     fetch_fault,
  input  logic [FAULT_W-1:0]       fault_code,
  input  logic [LINE_BITS-1:0]     line_data,
  input  logic [SLOTS-1:0]         pred_taken,
  input  logic [SLOTS*ADDR_W-1:0]  pred_target,
  output logic [ADDR_W-1:0]        req_addr,
  output logic [ADDR_W-1:0]        thread_pc,
  output logic [ADDR_W-1:0]        thread_npc,
  output logic [SLOTS-1:0]         slot_valid,
  output logic [CNT_W-1:0]         slot_count,
  output logic                     wr_active,
  output logic [SLOTS*INST_W-1:0]  slot_inst,
  output logic [SLOTS*ADDR_W-1:0]  slot_pc,
  output logic [SLOTS*SEQ_W-1:0]   slot_seq,
  output logic [SLOTS*ADDR_W-1:0]  slot_npc,
  output logic                     slot_fault,
  output logic [FAULT_W-1:0]       slot_fault_code,
  output logic                     quiesce_pending,
  output logic                     trap_pending
);
  // events between the pieces, named for the assertions
  logic [SLOTS-1:0]        c_valid;
  logic [SLOTS*INST_W-1:0] c_inst;
  logic [SLOTS*ADDR_W-1:0] c_spc;
  logic [SLOTS*ADDR_W-1:0] c_npc;
  logic [CNT_W-1:0]        c_count;
  logic [ADDR_W-1:0]       c_last_npc;
  logic                    c_quiesce;
  logic [ADDR_W-1:0]       pc_q;
  logic [SEQ_W-1:0]        seq_q;
  logic                    accept;
  logic                    take_fault;
  logic                    take_group;
  logic [SLOTS*SEQ_W-1:0]  seq_next;

  fx_slot_chain #(.SLOTS(SLOTS), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chain (
    .pc(pc_q), .line(line_data), .taken(pred_taken), .target(pred_target),
    .valid(c_valid), .insts(c_inst), .spcs(c_spc), .npcs(c_npc),
    .count(c_count), .last_npc(c_last_npc), .quiesce_hit(c_quiesce)
  );

  fx_thread_state #(.ADDR_W(ADDR_W), .SEQ_W(SEQ_W), .CNT_W(CNT_W),
                    .RESET_PC(RESET_PC)) u_state (
    .clk(clk), .rst_n(rst_n), .redirect_valid(redirect_valid),
    .redirect_pc(redirect_pc), .fetch_valid(fetch_valid),
    .fetch_fault(fetch_fault), .count(c_count), .last_npc(c_last_npc),
    .quiesce_hit(c_quiesce), .pc_q(pc_q), .npc_q(thread_npc), .seq_q(seq_q),
    .qp_q(quiesce_pending), .tp_q(trap_pending), .accept(accept)
  );

  assign take_fault = accept && fetch_fault;
  assign take_group = accept && !fetch_fault;
  assign thread_pc  = pc_q;
  assign req_addr   = {pc_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign wr_active  = |slot_valid;

  for (genvar i = 0; i < SLOTS; i++) begin : g_seq
    assign seq_next[i*SEQ_W +: SEQ_W] = seq_q + SEQ_W'(i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_valid      <= '0;
      slot_count      <= '0;
      slot_inst       <= '0;
      slot_pc         <= '0;
      slot_seq        <= '0;
      slot_npc        <= '0;
      slot_fault      <= 1'b0;
      slot_fault_code <= '0;
    end else if (take_fault) begin
      slot_valid               <= SLOTS'(1);
      slot_count               <= CNT_W'(1);
      slot_inst                <= '0;
      slot_inst[INST_W-1:0]    <= NOP_WORD;
      slot_pc                  <= '0;
      slot_pc[ADDR_W-1:0]      <= c_spc[ADDR_W-1:0];
      slot_npc                 <= '0;
      slot_npc[ADDR_W-1:0]     <= c_spc[ADDR_W-1:0] + ADDR_W'(INST_BYTES);
      slot_seq                 <= seq_next;
      slot_fault               <= 1'b1;
      slot_fault_code          <= fault_code;
    end else if (take_group) begin
      slot_valid      <= c_valid;
      slot_count      <= c_count;
      slot_inst       <= c_inst;
      slot_pc         <= c_spc;
      slot_npc        <= c_npc;
      slot_seq        <= seq_next;
      slot_fault      <= 1'b0;
      slot_fault_code <= '0;
    end else begin
      slot_valid      <= '0;
      slot_count      <= '0;
      slot_fault      <= 1'b0;
      slot_fault_code <= '0;
    end
  end

  // R3: count and mask come from separate logic and must agree
  a_r3_count_matches: assert property (@(posedge clk) disable iff (!rst_n)
    slot_count == CNT_W'($countones(slot_valid)));
  // R3: valid slots form an unbroken run from slot 0
  a_r3_mask_prefix: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_valid & (slot_valid + SLOTS'(1))) == '0);
  // R8: a fault group is a single slot
  a_r8_fault_single: assert property (@(posedge clk) disable iff (!rst_n)
    slot_fault |-> slot_valid == SLOTS'(1) && slot_count == CNT_W'(1));
  // R10: nothing is emitted while waiting
  a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (quiesce_pending || trap_pending) && !redirect_valid |=> !wr_active);
  // R11: a redirect wins over a same-cycle line
  a_r11_redirect_wins: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |=> !wr_active && thread_pc == $past(redirect_pc)
                       && !quiesce_pending && !trap_pending);
endmodule

// File: tb/tb_fx_group_extract.sv
module tb_fx_group_extract;
  localparam int W  = 4;
  localparam int AW = 32;
  localparam int SW = 16;
  localparam int FW = 4;
  localparam int CW = 3;
  localparam logic [31:0] RST_PC = 32'h0000_1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic redirect_valid = 1'b0;
  logic [AW-1:0] redirect_pc = '0;
  logic fetch_valid = 1'b0;
  logic fetch_fault = 1'b0;
  logic [FW-1:0] fault_code = '0;
  logic [511:0] line_data;
  logic [W-1:0] pred_taken = '0;
  logic [W*AW-1:0] pred_target;
  logic [AW-1:0] req_addr, thread_pc, thread_npc;
  logic [W-1:0] slot_valid;
  logic [CW-1:0] slot_count;
  logic wr_active;
  logic [W*32-1:0] slot_inst;
  logic [W*AW-1:0] slot_pc, slot_npc;
  logic [W*SW-1:0] slot_seq;
  logic slot_fault;
  logic [FW-1:0] slot_fault_code;
  logic quiesce_pending, trap_pending;

  logic [31:0] line_w [16];
  logic [31:0] ptgt [W];

  always #5 clk = ~clk;

  always_comb begin
    for (int k = 0; k < 16; k++) line_data[32*k +: 32] = line_w[k];
    for (int k = 0; k < W; k++) pred_target[AW*k +: AW] = ptgt[k];
  end

  fx_group_extract #(.SLOTS(W), .ADDR_W(AW), .SEQ_W(SW), .FAULT_W(FW),
                     .RESET_PC(RST_PC)) dut (
    .clk(clk), .rst_n(rst_n), .redirect_valid(redirect_valid),
    .redirect_pc(redirect_pc), .fetch_valid(fetch_valid),
    .fetch_fault(fetch_fault), .fault_code(fault_code), .line_data(line_data),
    .pred_taken(pred_taken), .pred_target(pred_target), .req_addr(req_addr),
    .thread_pc(thread_pc), .thread_npc(thread_npc), .slot_valid(slot_valid),
    .slot_count(slot_count), .wr_active(wr_active), .slot_inst(slot_inst),
    .slot_pc(slot_pc), .slot_seq(slot_seq), .slot_npc(slot_npc),
    .slot_fault(slot_fault), .slot_fault_code(slot_fault_code),
    .quiesce_pending(quiesce_pending), .trap_pending(trap_pending)
  );

  typedef struct packed {
    logic [W-1:0]         mask;
    logic [CW-1:0]        cnt;
    logic [W-1:0][31:0]   inst;
    logic [W-1:0][31:0]   pc;
    logic [W-1:0][31:0]   npc;
    logic [W-1:0][15:0]   seq;
    logic                 flt;
    logic [FW-1:0]        code;
    logic [31:0]          tpc;
    logic [31:0]          tnpc;
    logic [31:0]          raddr;
    logic                 qp;
    logic                 tp;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];

  int n_checks = 0;
  int n_fail   = 0;

  logic [31:0] m_pc  = RST_PC;
  logic [31:0] m_npc = RST_PC + 32'd4;
  logic [15:0] m_seq = '0;
  logic        m_qp  = 1'b0;
  logic        m_tp  = 1'b0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  // driver: applies one cycle of stimulus and queues the expected result
  task automatic drive(input string tag, input bit rd, input logic [31:0] rpc,
                       input bit fv, input bit flt, input logic [FW-1:0] code);
    exp_t e;
    logic [31:0] base, cur, last, w;
    int off, k;
    bit stop;
    e = '0;
    @(negedge clk);
    redirect_valid = rd; redirect_pc = rpc;
    fetch_valid = fv; fetch_fault = flt; fault_code = code;
    if (rd) begin
      m_pc = rpc; m_npc = rpc + 32'd4; m_qp = 1'b0; m_tp = 1'b0;
    end else if (fv && !m_qp && !m_tp) begin
      base = {m_pc[31:6], 6'b0};
      off  = int'(m_pc[5:0]) & ~3;
      if (flt) begin
        e.mask = 1; e.cnt = 1; e.inst[0] = 32'h0000_0013;
        e.pc[0] = base + 32'(off); e.npc[0] = base + 32'(off) + 32'd4;
        e.seq[0] = m_seq; e.flt = 1'b1; e.code = code;
        m_seq++; m_tp = 1'b1;
      end else begin
        k = 0; stop = 0; last = m_pc;
        while (off < 64 && k < W && !stop) begin
          w = line_w[off/4];
          cur = base + 32'(off);
          e.mask[k] = 1'b1; e.inst[k] = w; e.pc[k] = cur; e.seq[k] = m_seq;
          m_seq++;
          if (w[31:30] == 2'b10 && pred_taken[k]) begin
            e.npc[k] = ptgt[k]; stop = 1;
          end else begin
            e.npc[k] = cur + 32'd4;
            if (w[31:24] == 8'h7F) begin stop = 1; m_qp = 1'b1; end
          end
          last = e.npc[k];
          k++; off += 4;
        end
        e.cnt = CW'(k); m_pc = last; m_npc = last + 32'd4;
      end
    end
    e.tpc = m_pc; e.tnpc = m_npc; e.raddr = {m_pc[31:6], 6'b0};
    e.qp = m_qp; e.tp = m_tp;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(posedge clk); #2;
  endtask

  // monitor: compares each cycle's outputs against the queued item
  initial begin
    exp_t  e;
    string t;
    forever begin
      @(posedge clk); #1;
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(slot_valid == e.mask && slot_count == e.cnt &&
              wr_active == (e.mask != 0), t, "mask/count",
              {slot_valid, 4'h0, 5'(slot_count), wr_active},
              {e.mask, 4'h0, 5'(e.cnt), (e.mask != 0)});
        for (int k = 0; k < W; k++) begin
          if (e.mask[k]) begin
            check(slot_inst[32*k +: 32] == e.inst[k], t, "inst",
                  64'(slot_inst[32*k +: 32]), 64'(e.inst[k]));
            check(slot_pc[AW*k +: AW] == e.pc[k], t, "pc",
                  64'(slot_pc[AW*k +: AW]), 64'(e.pc[k]));
            check(slot_npc[AW*k +: AW] == e.npc[k], t, "npc",
                  64'(slot_npc[AW*k +: AW]), 64'(e.npc[k]));
            check(slot_seq[SW*k +: SW] == e.seq[k], t, "seq",
                  64'(slot_seq[SW*k +: SW]), 64'(e.seq[k]));
          end
        end
        check(slot_fault == e.flt && (!e.flt || slot_fault_code == e.code),
              t, "fault", {slot_fault, slot_fault_code}, {e.flt, e.code});
        check(thread_pc == e.tpc && thread_npc == e.tnpc && req_addr == e.raddr,
              t, "thread pc/npc", {thread_pc, thread_npc}, {e.tpc, e.tnpc});
        check(quiesce_pending == e.qp && trap_pending == e.tp, t, "pending",
              {quiesce_pending, trap_pending}, {e.qp, e.tp});
      end
    end
  end

  initial begin
    #(200000 * 10);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    for (int k = 0; k < 16; k++) line_w[k] = 32'h0100_0000 + 32'(k);
    for (int k = 0; k < W; k++) ptgt[k] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: state during reset
    check(slot_valid == '0 && !slot_fault && !quiesce_pending && !trap_pending,
          "R1", "reset outputs", {slot_valid, slot_fault}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check(thread_pc == RST_PC && thread_npc == RST_PC + 32'd4 &&
          req_addr == RST_PC && !wr_active, "R1", "post-reset pc",
          {thread_pc, thread_npc}, {RST_PC, RST_PC + 32'd4});

    drive("R3 R4 R9 R12 full group", 0, 0, 1, 0, 0);
    drive("R5 seq continues", 0, 0, 1, 0, 0);
    drive("R11 redirect", 1, 32'h0000_1038, 0, 0, 0);
    drive("R2 R3 line end", 0, 0, 1, 0, 0);
    drive("R11 redirect unaligned", 1, 32'h0000_1106, 0, 0, 0);
    drive("R2 unaligned start", 0, 0, 1, 0, 0);

    drive("R11 redirect", 1, 32'h0000_2000, 0, 0, 0);
    line_w[1] = 32'h8000_0001; pred_taken = 4'b0010; ptgt[1] = 32'h0000_3000;
    drive("R6 taken ends group", 0, 0, 1, 0, 0);
    pred_taken = 4'b0000;
    drive("R6 not taken continues", 0, 0, 1, 0, 0);
    line_w[1] = 32'h0100_0001;

    drive("R11 redirect", 1, 32'h0000_4000, 0, 0, 0);
    line_w[2] = 32'h7F00_0000;
    drive("R7 quiesce", 0, 0, 1, 0, 0);
    drive("R10 quiesce blocks fetch", 0, 0, 1, 0, 0);
    line_w[2] = 32'h0100_0002;

    drive("R11 redirect clears quiesce", 1, 32'h0000_5008, 0, 0, 0);
    drive("R8 fault nop", 0, 0, 1, 1, 4'hA);
    drive("R10 trap blocks fetch", 0, 0, 1, 0, 0);
    drive("R11 redirect wins over fetch", 1, 32'h0000_6000, 1, 0, 0);

    drive("R11 redirect", 1, 32'h0000_603C, 0, 0, 0);
    line_w[15] = 32'h8000_0002; pred_taken = 4'b0001; ptgt[0] = 32'h0000_7000;
    drive("R6 R3 taken at line end", 0, 0, 1, 0, 0);
    pred_taken = 4'b0000;
    drive("R5 R9 after branch", 0, 0, 1, 0, 0);
    drive("R12 idle", 0, 0, 0, 0, 0);
    drive("R12 idle", 0, 0, 0, 0, 0);
    repeat (3) @(posedge clk);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule